// File: doc/BRIEF.md
# Four-Phase Parallel Link Device Controller

This block sits on the device end of an 8-bit parallel link whose transfers are always started by a host. Each byte moves under a four-phase handshake. The host sets the direction strobes and, for a write, the data bus. It then raises a request. The device performs the transfer and raises a busy/acknowledge line. The device holds that line until the host withdraws the request, and then drops it. The request and the two direction strobes arrive without a clock, so each of them is passed through a two-flop synchronizer before any decision uses it.

Above the byte handshake the controller adds array framing and keeps all array positions itself. In a write frame, the first byte is an element count N, and the N bytes that follow are stored at addresses 0 to N-1 of an external asynchronous-read memory. In a read frame, the first byte returned is the stored count, and the stored elements follow in order. Once the last element has been returned, the next read opens a new frame by returning the count again. The tri-state pad is left to the pad ring: the controller provides the outgoing byte and an output enable.

Top module: `pport_slave`

## Requirements
- R1: After reset `dev_bsy`, `bus_oe` and `mem_we` are 0, and a write frame and a read frame both start at their count byte.
- R2: With the default synchronizer depth of 2, `dev_bsy` rises at the third rising clock edge at which `host_req` is high. It never rises unless the synchronized request was high.
- R3: `mem_we` is a single-cycle pulse issued once for each accepted element byte of a write frame, and never for a count byte.
- R4: `dev_bsy` stays high as long as the synchronized request stays high. It falls at the third rising edge after `host_req` goes low, and the controller then waits for the next request.
- R5: A write frame's first byte N sets the stored length. The next N written bytes go to addresses 0, 1, ..., N-1, and the byte after them is taken as a new count. A count of 0 closes the frame at once.
- R6: `bus_oe` is high only during the acknowledge phase of a read transfer. It rises together with `dev_bsy` and falls together with it. `bus_o` is stable while `bus_oe` is high.
- R7: A read frame returns the stored length first and then elements 0 to length-1 in order. The read after the last element returns the length again. With length 0, every read returns 0.
- R8: When `host_wr` and `host_rd` are both high, the transfer is handled as a write: the bus is not driven and the byte is framed as written data.
- R9: Accepting a write count byte restarts the read frame, so the next read returns the new length.
- R10: A request with neither direction strobe is acknowledged. It writes nothing and leaves both frame positions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host transfer request (unsynchronized) |
| host_wr | input | 1 | Host write strobe (unsynchronized) |
| host_rd | input | 1 | Host read strobe (unsynchronized) |
| bus_i | input | 8 | Byte seen on the link bus |
| bus_o | output | 8 | Byte driven toward the link bus |
| bus_oe | output | 1 | Output enable for the bus pad |
| dev_bsy | output | 1 | Busy/acknowledge toward the host |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as the address |

## Verification
Write and read requests can fall in the same cycle when the host raises both direction strobes for one request. The arbitration then has to pick exactly one frame action on the edge where the request is accepted. The bench provokes this in the middle of a write frame. It judges the result in three ways: the bus enable must stay low for the whole handshake, the element must appear at the next write address, and a later read must return it at its place in the array. A per-clock behavioural model also flags any edge where busy, the enable or the write strobe depart from the expected sequence.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [0:0] {
    HS_IDLE = 1'b0,
    HS_ACK  = 1'b1
  } hs_state_t;

  typedef struct packed {
    logic req;
    logic wr;
    logic rd;
  } strobe_t;

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[CHAIN_W-W-1:0], d};
      end
    end
  endgenerate

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/pport_hs.sv
module pport_hs
  import pport_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_s,
  input  logic              wr_s,
  input  logic              rd_s,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              wr_go,
  output logic              rd_go,
  output logic              bsy,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe
);
  hs_state_t state;
  logic      accept_evt;
  logic      release_evt;

  assign accept_evt  = (state == HS_IDLE) && req_s;
  assign release_evt = (state == HS_ACK) && !req_s;
  assign wr_go       = accept_evt && wr_s;
  assign rd_go       = accept_evt && rd_s && !wr_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= HS_IDLE;
      bsy    <= 1'b0;
      bus_oe <= 1'b0;
      bus_o  <= '0;
    end else if (accept_evt) begin
      state  <= HS_ACK;
      bsy    <= 1'b1;
      bus_oe <= rd_go;
      if (rd_go) bus_o <= rd_byte;
    end else if (release_evt) begin
      state  <= HS_IDLE;
      bsy    <= 1'b0;
      bus_oe <= 1'b0;
    end
  end

  AST_BSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy) |-> $past(req_s)); // R2
  AST_BSY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && req_s) |=> bsy); // R4
  AST_BSY_DROP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bsy) |-> !$past(req_s)); // R4
  AST_OE_INSIDE_BSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> bsy); // R6
  AST_OE_FALLS_WITH_BSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> $fell(bsy)); // R6
  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_o)); // R6
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> !bus_oe); // R8
endmodule

// File: rtl/pport_frame.sv
module pport_frame #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [DATA_W-1:0] bus_byte,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] rd_byte
);
  localparam int unsigned CW = DATA_W + 1;

  function automatic logic [DATA_W-1:0] bump(input logic [DATA_W-1:0] p);
    return p + DATA_W'(1);
  endfunction

  function automatic logic is_last(input logic [DATA_W-1:0] p,
                                   input logic [DATA_W-1:0] l);
    return ({1'b0, p} + CW'(1)) == {1'b0, l};
  endfunction

  logic [DATA_W-1:0] len;
  logic [DATA_W-1:0] wr_ptr;
  logic [DATA_W-1:0] rd_ptr;
  logic              wr_body;
  logic              rd_body;

  logic hdr_evt, elem_evt, rlen_evt, relem_evt;
  assign hdr_evt   = wr_go && !wr_body;
  assign elem_evt  = wr_go &&  wr_body;
  assign rlen_evt  = rd_go && !rd_body;
  assign relem_evt = rd_go &&  rd_body;

  assign mem_we    = elem_evt;
  assign mem_addr  = elem_evt ? wr_ptr : rd_ptr;
  assign mem_wdata = bus_byte;
  assign rd_byte   = rd_body ? mem_rdata : len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len     <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      wr_body <= 1'b0;
      rd_body <= 1'b0;
    end else begin
      if (hdr_evt) begin
        len     <= bus_byte;
        wr_ptr  <= '0;
        wr_body <= (bus_byte != '0);
        rd_ptr  <= '0;
        rd_body <= 1'b0;
      end
      if (elem_evt) begin
        wr_ptr <= bump(wr_ptr);
        if (is_last(wr_ptr, len)) wr_body <= 1'b0;
      end
      if (rlen_evt) begin
        rd_ptr  <= '0;
        rd_body <= (len != '0);
      end
      if (relem_evt) begin
        rd_ptr <= bump(rd_ptr);
        if (is_last(rd_ptr, len)) rd_body <= 1'b0;
      end
    end
  end

  AST_MEM_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R3
  AST_WPTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_body |-> (wr_ptr < len)); // R5
  AST_ZERO_COUNT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_evt && bus_byte == '0) |=> !wr_body); // R5
  AST_RPTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_body |-> (rd_ptr < len)); // R7
  AST_HDR_RESTARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_evt |=> (!rd_body && rd_ptr == '0)); // R9
  AST_IDLE_KEEPS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_go && !rd_go) |=> ($stable(wr_ptr) && $stable(rd_ptr))); // R10
endmodule

// File: rtl/pport_slave.sv
module pport_slave
  import pport_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe,
  output logic              dev_bsy,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int unsigned STB_W = $bits(strobe_t);

  strobe_t           raw_stb;
  strobe_t           syn_stb;
  logic [STB_W-1:0]  syn_bits;
  logic              wr_go;
  logic              rd_go;
  logic [DATA_W-1:0] rd_byte;

  assign raw_stb = '{req: host_req, wr: host_wr, rd: host_rd};
  assign syn_stb = strobe_t'(syn_bits);

  pport_sync #(.W(STB_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_stb),
    .q     (syn_bits)
  );

  pport_hs #(.DATA_W(DATA_W)) u_hs (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_s   (syn_stb.req),
    .wr_s    (syn_stb.wr),
    .rd_s    (syn_stb.rd),
    .rd_byte (rd_byte),
    .wr_go   (wr_go),
    .rd_go   (rd_go),
    .bsy     (dev_bsy),
    .bus_o   (bus_o),
    .bus_oe  (bus_oe)
  );

  pport_frame #(.DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go     (wr_go),
    .rd_go     (rd_go),
    .bus_byte  (bus_i),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rd_byte   (rd_byte)
  );

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_go, rd_go})); // R8
  AST_WE_ONLY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (syn_stb.req && syn_stb.wr && !dev_bsy)); // R3
endmodule

// File: tb/pport_slave_tb_top.sv
`timescale 1ns/1ps
module pport_slave_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_req = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] bus_i = 8'h00;
  logic [7:0] bus_o, mem_addr, mem_wdata, mem_rdata;
  logic       bus_oe, dev_bsy, mem_we;

  always #2 clk = ~clk;

  pport_slave dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_rd(host_rd), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
    .dev_bsy(dev_bsy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // external storage
  logic [7:0] ram [256];
  initial for (int i = 0; i < 256; i++) ram[i] = 8'h00;
  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;
  assign mem_rdata = ram[mem_addr];

  int  vectors = 0, miscompares = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model, stepped on each rising edge
  int m_r1, m_r2, m_w1, m_w2, m_d1, m_d2;
  int m_st, m_bsy, m_oe, m_out;
  int m_len, m_wn, m_wi, m_ri;
  bit m_whdr, m_rhdr;
  int m_arr [256];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_w1 = 0; m_w2 = 0; m_d1 = 0; m_d2 = 0;
      m_st = 0; m_bsy = 0; m_oe = 0; m_out = 0;
      m_len = 0; m_wn = 0; m_wi = 0; m_ri = 0;
      m_whdr = 1; m_rhdr = 1;
      for (int i = 0; i < 256; i++) m_arr[i] = 0;
    end else begin
      if (m_st == 0 && m_r2 != 0) begin
        if (m_w2 != 0) begin
          if (m_whdr) begin
            m_len = bus_i; m_wn = bus_i; m_wi = 0;
            m_whdr = (bus_i == 0); m_rhdr = 1; m_ri = 0;
          end else begin
            m_arr[m_wi] = bus_i; m_wi++;
            if (m_wi == m_wn) m_whdr = 1;
          end
          m_oe = 0;
        end else if (m_d2 != 0) begin
          if (m_rhdr) begin
            m_out = m_len; m_ri = 0; m_rhdr = (m_len == 0);
          end else begin
            m_out = m_arr[m_ri]; m_ri++;
            if (m_ri == m_len) m_rhdr = 1;
          end
          m_oe = 1;
        end else m_oe = 0;
        m_bsy = 1; m_st = 1;
      end else if (m_st == 1 && m_r2 == 0) begin
        m_bsy = 0; m_oe = 0; m_st = 0;
      end
      m_r2 = m_r1; m_r1 = host_req;
      m_w2 = m_w1; m_w1 = host_wr;
      m_d2 = m_d1; m_d1 = host_rd;
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_we;
      exp_we = (m_st == 0) && (m_r2 != 0) && (m_w2 != 0) && !m_whdr;
      chk(dev_bsy == m_bsy[0], "R4 busy sequence", dev_bsy, m_bsy);
      chk(bus_oe == m_oe[0], "R6 enable sequence", bus_oe, m_oe);
      if (m_oe != 0) chk(bus_o == m_out[7:0], "R7 driven byte", bus_o, m_out);
      chk(mem_we == exp_we, "R3 write strobe", mem_we, exp_we);
      if (exp_we) chk(mem_addr == m_wi[7:0], "R5 write address", mem_addr, m_wi);
    end
  end

  task automatic xfer(input bit w, input bit r, input int d,
                      output int got, output int lat_up, output int lat_dn,
                      output bit saw_oe);
    @(negedge clk); host_wr = w; host_rd = r; bus_i = d[7:0];
    @(negedge clk); host_req = 1'b1; lat_up = 0; saw_oe = 0;
    do begin @(negedge clk); lat_up++; if (bus_oe) saw_oe = 1; end
    while (!dev_bsy && lat_up < 50);
    got = bus_o;
    host_req = 1'b0; lat_dn = 0;
    do begin @(negedge clk); lat_dn++; if (bus_oe) saw_oe = 1; end
    while (dev_bsy && lat_dn < 50);
    host_wr = 1'b0; host_rd = 1'b0; bus_i = 8'hA5;
  endtask

  task automatic put(input int d, input bit both);
    int g, lu, ld; bit so;
    xfer(1'b1, both, d, g, lu, ld, so);
    chk(lu == 3, "R2 acknowledge latency", lu, 3);
    chk(ld == 3, "R4 release latency", ld, 3);
    chk(!so, both ? "R8 bus driven on dual strobe" : "R6 bus driven on write", so, 0);
  endtask

  task automatic get(input int exp, input string tag);
    int g, lu, ld; bit so;
    xfer(1'b0, 1'b1, 0, g, lu, ld, so);
    chk(g == exp, tag, g, exp);
    chk(so, "R6 enable during read", so, 1);
    chk(lu == 3, "R2 acknowledge latency", lu, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(dev_bsy == 0, "R1 busy after reset", dev_bsy, 0);
    chk(bus_oe == 0, "R1 enable after reset", bus_oe, 0);
    chk(mem_we == 0, "R1 strobe after reset", mem_we, 0);
    get(0, "R1 first read returns empty length");

    // R5 R7 basic frame {7,8}
    put(2, 0); put(7, 0); put(8, 0);
    chk(ram[0] == 7 && ram[1] == 8, "R5 elements at 0 and 1", ram[1], 8);
    get(2, "R7 length first");
    get(7, "R7 element 0");
    get(8, "R7 element 1");
    get(2, "R7 length again after last");

    // R10 no strobe between reads
    begin
      int g, lu, ld; bit so;
      get(7, "R7 element 0 of new frame");
      xfer(1'b0, 1'b0, 8'h3C, g, lu, ld, so);
      chk(lu == 3, "R10 idle request acknowledged", lu, 3);
      chk(!so, "R10 idle request not driven", so, 0);
      get(8, "R10 read position unchanged");
    end

    // R5 R7 zero-length frame
    put(0, 0);
    get(0, "R7 zero length read");
    get(0, "R7 zero length read repeated");

    // R9 write count restarts read frame
    put(4, 0); put(10, 0); put(11, 0); put(12, 0); put(13, 0);
    get(4, "R9 length of four");
    get(10, "R9 first element");
    put(1, 0); put(99, 0);
    get(1, "R9 new length after restart");
    get(99, "R9 new element");

    // R8 both strobes inside a write frame
    put(2, 0);
    put(55, 1);
    put(66, 0);
    chk(ram[0] == 55, "R8 dual-strobe byte stored", ram[0], 55);
    get(2, "R8 length");
    get(55, "R8 element from dual strobe");
    get(66, "R8 following element");

    // R3 R5 longer array
    put(20, 0);
    for (int i = 0; i < 20; i++) put((i * 7 + 3) & 255, 0);
    get(20, "R5 long length");
    for (int i = 0; i < 20; i++) get((i * 7 + 3) & 255, "R3 long element");
    get(20, "R7 long wrap");

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule